// File: doc/BRIEF.md
# Packed Lane Permute and Pack Unit

This unit rearranges the lanes of two 64-bit operands, `src_a` and `src_b`. The operation is picked by a 4-bit code. The unit supports these operations:

- a halfword shuffle, with the lane selectors taken from `src_b`;
- three narrowing packs that saturate wider signed lanes into narrower ones;
- interleaves of the low or high halves of both operands, at byte, halfword and word granularity;
- four halfword inserts, each at a fixed lane position;
- a halfword extract, at a lane position given in `src_b`.

Every candidate result is formed in parallel logic. The operation code selects one of them. The selected value is captured in a single output register, so each result appears one clock after its operands and code.

Halfword lane i occupies bits [16i+15:16i]. Byte lane i occupies bits [8i+7:8i]. Word lane i occupies bits [32i+31:32i].

Top module: `lane_permute_unit`

## Requirements
- R1: The result register clears to zero on a clock edge with `rst_n` low. Otherwise it takes, on each rising edge, the value selected by the code and operands presented before that edge, and holds it until the next edge.
- R2: Code 1 (shuffle): result halfword i equals halfword `src_b[2i+1:2i]` of `src_a`, for i = 0..3. Bits of `src_b` above bit 7 have no effect.
- R3: Code 2 (word-to-halfword pack): each signed 32-bit word is clamped to -32768..32767. `src_a` words 0 and 1 go to result halfwords 0 and 1; `src_b` words 0 and 1 go to halfwords 2 and 3.
- R4: Code 3 (signed halfword-to-byte pack): each signed halfword is clamped to -128..127. `src_a` halfwords 0..3 go to result bytes 0..3; `src_b` halfwords 0..3 go to bytes 4..7.
- R5: Code 4 (unsigned halfword-to-byte pack) uses the lane placement of R4. A negative halfword gives 0, and a halfword above 255 gives 255.
- R6: Codes 5 and 6 (halfword interleave): from least significant, the result halfwords are a0, b0, a1, b1 for code 5 and a2, b2, a3, b3 for code 6.
- R7: Codes 7 and 8 (byte interleave): the result bytes alternate `src_a` and `src_b` bytes, starting with `src_a`. Code 7 draws on bytes 0..3 and code 8 on bytes 4..7.
- R8: Codes 9 and 10 (word interleave): bits 31:0 carry the `src_a` word and bits 63:32 carry the `src_b` word. Code 9 uses word 0 of each operand and code 10 uses word 1.
- R9: Codes 11..14 (insert): result = `src_a` with halfword n = code-11 replaced by `src_b[15:0]`. All other bits are unchanged.
- R10: Code 15 (extract): result = halfword `src_b[1:0]` of `src_a`, zero-extended to 64 bits.
- R11: Code 0 is unused and yields a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 4 | Operation select |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand, or selector and insert data |
| result | output | 64 | Registered result |

## Verification
The packs and the extract are the two functions where two behaviours meet in one cycle.

In a single pack operation, some lanes saturate while neighbouring lanes pass through unchanged. The vectors mix in-range lanes, lanes exactly at each limit, lanes one step past each limit, and negative lanes fed to the unsigned pack. Each result byte or halfword is compared against a hand-worked value.

Shuffle and extract reuse `src_b` as a selector. The vectors therefore fill its unused upper bits with ones to show those bits have no effect.

Back-to-back operations of different codes check that each registered result reflects only the preceding edge.

// File: rtl/lane_perm_pkg.sv
// Package: shared operation codes, lane widths and saturation helpers
// for the lane permute unit. Assumes two's-complement signed lanes.
package lane_perm_pkg;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_SHUF   = 4'd1,
        OP_PK_WH  = 4'd2,
        OP_PK_HBS = 4'd3,
        OP_PK_HBU = 4'd4,
        OP_ZLO_H  = 4'd5,
        OP_ZHI_H  = 4'd6,
        OP_ZLO_B  = 4'd7,
        OP_ZHI_B  = 4'd8,
        OP_ZLO_W  = 4'd9,
        OP_ZHI_W  = 4'd10,
        OP_INS0   = 4'd11,
        OP_INS1   = 4'd12,
        OP_INS2   = 4'd13,
        OP_INS3   = 4'd14,
        OP_EXTR   = 4'd15
    } perm_op_e;

    // Clamp a signed word into the signed halfword range.
    function automatic logic [HALF_W-1:0] sat_w_to_sh(input logic signed [WORD_W-1:0] v);
        if (v > 32'sd32767)
            return 16'h7fff;
        else if (v < -32'sd32768)
            return 16'h8000;
        else
            return v[HALF_W-1:0];
    endfunction

    // Clamp a signed halfword into the signed byte range.
    function automatic logic [BYTE_W-1:0] sat_h_to_sb(input logic signed [HALF_W-1:0] v);
        if (v > 16'sd127)
            return 8'h7f;
        else if (v < -16'sd128)
            return 8'h80;
        else
            return v[BYTE_W-1:0];
    endfunction

    // Clamp a signed halfword into the unsigned byte range.
    function automatic logic [BYTE_W-1:0] sat_h_to_ub(input logic signed [HALF_W-1:0] v);
        if (v < 16'sd0)
            return 8'h00;
        else if (v > 16'sd255)
            return 8'hff;
        else
            return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/lane_pack.sv
// Module: lane_pack
// Narrows the lanes of two operands into one result, saturating each lane.
// Operand a fills the low half of each result, operand b fills the high half.
// Assumes DW is a multiple of 32.
module lane_pack
    import lane_perm_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] pk_wh,
    output logic [DW-1:0] pk_hbs,
    output logic [DW-1:0] pk_hbu
);
    localparam int NW = DW / WORD_W;
    localparam int NH = DW / HALF_W;

    // Word-to-halfword lanes: a word w goes to halfword w, b word w to halfword NW+w.
    for (genvar w = 0; w < NW; w++) begin : g_wh
        assign pk_wh[w*HALF_W +: HALF_W]      = sat_w_to_sh(a[w*WORD_W +: WORD_W]);
        assign pk_wh[(NW+w)*HALF_W +: HALF_W] = sat_w_to_sh(b[w*WORD_W +: WORD_W]);
    end

    // Halfword-to-byte lanes: a half h goes to byte h, b half h to byte NH+h.
    for (genvar h = 0; h < NH; h++) begin : g_hb
        assign pk_hbs[h*BYTE_W +: BYTE_W]      = sat_h_to_sb(a[h*HALF_W +: HALF_W]);
        assign pk_hbs[(NH+h)*BYTE_W +: BYTE_W] = sat_h_to_sb(b[h*HALF_W +: HALF_W]);
        assign pk_hbu[h*BYTE_W +: BYTE_W]      = sat_h_to_ub(a[h*HALF_W +: HALF_W]);
        assign pk_hbu[(NH+h)*BYTE_W +: BYTE_W] = sat_h_to_ub(b[h*HALF_W +: HALF_W]);
    end
endmodule

// File: rtl/lane_zip.sv
// Module: lane_zip
// Interleaves the low (lo) or high (hi) half of the LW-bit lanes of a and b.
// Operand a always lands in the even lanes.
// Assumes DW / LW is even.
module lane_zip #(
    parameter int DW = 64,
    parameter int LW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] lo,
    output logic [DW-1:0] hi
);
    localparam int N    = DW / LW;
    localparam int HALF = N / 2;

    // Lane k of each source half goes to result lanes 2k (a) and 2k+1 (b).
    for (genvar k = 0; k < HALF; k++) begin : g_lane
        assign lo[(2*k)*LW   +: LW] = a[k*LW +: LW];
        assign lo[(2*k+1)*LW +: LW] = b[k*LW +: LW];
        assign hi[(2*k)*LW   +: LW] = a[(k+HALF)*LW +: LW];
        assign hi[(2*k+1)*LW +: LW] = b[(k+HALF)*LW +: LW];
    end
endmodule

// File: rtl/lane_select.sv
// Module: lane_select
// Halfword selection paths: the shuffle picks each result halfword with
// its own selector from b, the extract picks one halfword and zero-extends
// it, and the inserts place b's low halfword into each fixed lane.
module lane_select
    import lane_perm_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0]          a,
    input  logic [DW-1:0]          b,
    output logic [DW-1:0]          shuf,
    output logic [DW-1:0]          extr,
    output logic [DW/HALF_W-1:0][DW-1:0] ins
);
    localparam int NH    = DW / HALF_W;
    localparam int SEL_W = $clog2(NH);

    // Shuffle: result halfword i is taken from a at the index in b[SEL_W*i +: SEL_W].
    for (genvar i = 0; i < NH; i++) begin : g_shuf
        logic [SEL_W-1:0] sel;
        assign sel = b[i*SEL_W +: SEL_W];
        assign shuf[i*HALF_W +: HALF_W] = a[sel*HALF_W +: HALF_W];
    end

    // Extract: one halfword chosen by the low selector bits of b, zero-extended.
    logic [SEL_W-1:0] ext_sel;
    assign ext_sel = b[SEL_W-1:0];
    always_comb begin
        extr = '0;
        extr[HALF_W-1:0] = a[ext_sel*HALF_W +: HALF_W];
    end

    // Insert: variant n replaces halfword n of a with b's low halfword.
    for (genvar n = 0; n < NH; n++) begin : g_ins
        always_comb begin
            ins[n] = a;
            ins[n][n*HALF_W +: HALF_W] = b[HALF_W-1:0];
        end
    end
endmodule

// File: rtl/lane_permute_unit.sv
// Module: lane_permute_unit (top)
// Forms every lane permutation of src_a and src_b in parallel. The op code
// selects one candidate, which is registered, so results come one clock
// after the inputs. Synchronous active-low reset clears the result.
// Assumes DW = 64 for the fixed 4-bit code space.
module lane_permute_unit
    import lane_perm_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic [DW-1:0] result
);
    localparam int NH     = DW / HALF_W;
    localparam int NZIP   = 3;

    logic [DW-1:0] shuf, extr, pk_wh, pk_hbs, pk_hbu;
    logic [NH-1:0][DW-1:0]   ins;
    logic [NZIP-1:0][DW-1:0] zip_lo, zip_hi;
    logic [DW-1:0] nxt, res_q;
    perm_op_e op;

    assign op = perm_op_e'(op_code);

    lane_select #(.DW(DW)) u_sel (
        .a(src_a), .b(src_b), .shuf(shuf), .extr(extr), .ins(ins)
    );

    lane_pack #(.DW(DW)) u_pack (
        .a(src_a), .b(src_b), .pk_wh(pk_wh), .pk_hbs(pk_hbs), .pk_hbu(pk_hbu)
    );

    // One interleaver per lane width: index 0 bytes, 1 halfwords, 2 words.
    for (genvar g = 0; g < NZIP; g++) begin : g_zip
        lane_zip #(.DW(DW), .LW(BYTE_W << g)) u_zip (
            .a(src_a), .b(src_b), .lo(zip_lo[g]), .hi(zip_hi[g])
        );
    end

    // Pick the candidate named by the operation code.
    always_comb begin
        unique case (op)
            OP_SHUF:   nxt = shuf;
            OP_PK_WH:  nxt = pk_wh;
            OP_PK_HBS: nxt = pk_hbs;
            OP_PK_HBU: nxt = pk_hbu;
            OP_ZLO_H:  nxt = zip_lo[1];
            OP_ZHI_H:  nxt = zip_hi[1];
            OP_ZLO_B:  nxt = zip_lo[0];
            OP_ZHI_B:  nxt = zip_hi[0];
            OP_ZLO_W:  nxt = zip_lo[2];
            OP_ZHI_W:  nxt = zip_hi[2];
            OP_INS0:   nxt = ins[0];
            OP_INS1:   nxt = ins[1];
            OP_INS2:   nxt = ins[2];
            OP_INS3:   nxt = ins[3];
            OP_EXTR:   nxt = extr;
            default:   nxt = '0;
        endcase
    end

    // Result register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= nxt;
    end

    assign result = res_q;
endmodule

// File: rtl/lane_permute_unit_chk.sv
// Module: lane_permute_unit_chk
// Temporal checks on the ports of lane_permute_unit, attached by bind.
module lane_permute_unit_chk #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_code,
    input logic [DW-1:0] src_a,
    input logic [DW-1:0] src_b,
    input logic [DW-1:0] result
);
    // R11: the unused code gives zero on the next edge.
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd0) |=> (result == '0));

    // R10: extract leaves every bit above the low halfword clear.
    a_r10_extract_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd15) |=> (result[DW-1:16] == '0));

    // R9: insert at lane 0 keeps the rest of src_a.
    a_r9_insert_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd11) |=> (result[DW-1:16] == $past(src_a[DW-1:16])));

    // R8: low word interleave places both low words side by side.
    a_r8_word_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd9) |=> (result == {$past(src_b[DW/2-1:0]), $past(src_a[DW/2-1:0])}));

    // R2: identity selectors reproduce src_a.
    a_r2_shuffle_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd1 && src_b[7:0] == 8'he4) |=> (result == $past(src_a)));
endmodule

bind lane_permute_unit lane_permute_unit_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .result(result)
);

// File: tb/lane_permute_unit_test.sv
module lane_permute_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;
    localparam logic [63:0] VA = 64'h8877_6655_4433_2211;
    localparam logic [63:0] VB = 64'hFFEE_DDCC_BBAA_9900;

    typedef struct packed {
        logic [3:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{4'd1, VA, 64'h0000_0000_0000_001B, 64'h2211_4433_6655_8877, 8'd2},  // R2 reversal
        '{4'd1, VA, 64'hFFFF_FFFF_FFFF_FF00, 64'h2211_2211_2211_2211, 8'd2},  // R2 upper b ignored
        '{4'd2, 64'hFFFF8000_00010000, 64'h80000000_00001234, 64'h8000_1234_8000_7FFF, 8'd3}, // R3
        '{4'd2, 64'hFFFF7FFF_00007FFF, 64'h7FFFFFFF_FFFFFFFF, 64'h7FFF_FFFF_8000_7FFF, 8'd3}, // R3
        '{4'd3, 64'hFF7F_FF80_0080_007F, 64'h7FFF_8000_0005_FFFF, 64'h7F80_05FF_8080_7F7F, 8'd4}, // R4
        '{4'd4, 64'hFF7F_FF80_0080_007F, 64'h7FFF_8000_0005_FFFF, 64'hFF00_0500_0000_807F, 8'd5}, // R5
        '{4'd4, 64'h0100_00FF_0000_0001, 64'h0, 64'h0000_0000_FFFF_0001, 8'd5},                  // R5
        '{4'd5, VA, VB, 64'hBBAA_4433_9900_2211, 8'd6},   // R6 low
        '{4'd6, VA, VB, 64'hFFEE_8877_DDCC_6655, 8'd6},   // R6 high
        '{4'd7, VA, VB, 64'hBB44_AA33_9922_0011, 8'd7},   // R7 low
        '{4'd8, VA, VB, 64'hFF88_EE77_DD66_CC55, 8'd7},   // R7 high
        '{4'd9, VA, VB, 64'hBBAA_9900_4433_2211, 8'd8},   // R8 low
        '{4'd10, VA, VB, 64'hFFEE_DDCC_8877_6655, 8'd8},  // R8 high
        '{4'd11, VA, VB, 64'h8877_6655_4433_9900, 8'd9},  // R9 lane 0
        '{4'd12, VA, VB, 64'h8877_6655_9900_2211, 8'd9},  // R9 lane 1
        '{4'd13, VA, VB, 64'h8877_9900_4433_2211, 8'd9},  // R9 lane 2
        '{4'd14, VA, VB, 64'h9900_6655_4433_2211, 8'd9},  // R9 lane 3
        '{4'd15, VA, 64'h3, 64'h0000_0000_0000_8877, 8'd10},                    // R10
        '{4'd15, VA, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_6655, 8'd10},  // R10
        '{4'd0, VA, VB, 64'h0, 8'd11}                                            // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] result;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    lane_permute_unit uut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        op_code = op;
        src_a   = a;
        src_b   = b;
    endtask

    initial begin
        // R1: reset state with active inputs present.
        drive(4'd1, VA, 64'h1B);
        repeat (3) @(negedge clk);
        check("R1 reset clears result", result, 64'h0);

        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive on a falling edge, check on the next falling edge.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].a, VECS[i].b);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].exp);
        end

        // R1: result holds until the next edge after inputs change.
        drive(4'd9, VA, VB);
        @(negedge clk);
        drive(4'd15, VA, 64'h0);
        #1;
        check("R1 holds before edge", result, 64'hBBAA_9900_4433_2211);
        @(negedge clk);
        check("R1 updates after edge (R10 lane 0)", result, 64'h0000_0000_0000_2211);

        // R5 / R4 boundary: 255 and 256 in the same pack.
        drive(4'd4, 64'h0, 64'h0000_0000_0100_00FF);
        @(negedge clk);
        check("R5 255 and 256", result, 64'h0000_FFFF_0000_0000);
        drive(4'd3, 64'h0, 64'h0000_0000_FF81_007E);
        @(negedge clk);
        check("R4 in range lanes", result, 64'h0000_817E_0000_0000);

        // R1: mid-run reset clears the register despite a live operation.
        drive(4'd5, VA, VB);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after reset release", result, 64'hBBAA_4433_9900_2211);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule